// File: doc/BRIEF.md
# Carry-save sign-estimating modular multiplier

The block computes A·B mod M by scanning the multiplier bits most significant first. It holds the running value in redundant sum/carry form, so no step ever propagates a carry across the word. Each step doubles the accumulator and adds B when the current bit of 8·A is set. It then pulls the value back toward zero by adding or subtracting 8·M. Which of the two it does depends on a cheap range estimate formed from the upper bits of the two carry-save words. The estimate is computed before the doubling, so it runs alongside the shift-and-add.

One step is split over two register stages. Stage one forms the estimate and the shift-and-add. Stage two applies the chosen ±8·M correction. A step of one job therefore takes two clocks, and two independent jobs share the datapath on alternate cycles. Each job is named by a one-bit tag, and the tag travels with the job's state through both stages. The modulus is used as given: it may be odd or even, and no constant is precomputed. Its top bit (bit N−1) must be set.

The result leaves in carry-save form with the job's tag and a one-cycle done pulse. The consumer adds the two words and interprets the sum as signed. If it is negative, the consumer adds 8·M. Shifting right by three then gives the product.

Top module: `csmm_mul`

## Requirements
- R1: For M with bit N−1 set and 0 ≤ A,B < M, let X be the N+5-bit signed value sum_o+carry_o at done_o. Then X, plus 8·M when X is negative, has its three low bits zero, and shifted right by three it equals A·B mod M.
- R2: X lies in the range −8·M to 7·M inclusive. The accumulator of every job in flight stays in this range after every correction stage.
- R3: Two jobs started with tag_i 0 and tag_i 1 run at the same time. Each returns exactly once, with tag_o equal to its own tag and its own correct product. The two stages never hold state of the same tag.
- R4: done_o is a one-cycle pulse per job. It rises 2N+6 or 2N+7 clock edges after the edge that samples the start, depending on the slot parity of the tag.
- R5: A start_i whose tag names a job still pending or in flight is ignored. The running job returns its original product, and no second result follows.
- R6: After reset, and with no start, done_o stays low and sum_o and carry_o stay zero.
- R7: Even moduli give correct products under R1.
- R8: A = 0 gives 0, and A = B = M−1 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job for tag_i with the operands present |
| tag_i | input | 1 | Job slot addressed by start_i |
| a_i | input | N | Multiplier A |
| b_i | input | N | Multiplicand B |
| m_i | input | N | Modulus M, bit N−1 set |
| done_o | output | 1 | Result valid, one cycle |
| tag_o | output | 1 | Tag of the finished job |
| sum_o | output | N+5 | Sum word of the carry-save result |
| carry_o | output | N+5 | Carry word of the carry-save result |

## Verification
The assertions check four things on every cycle. The accumulator of each in-flight job stays inside its reduction bound. A job's tag matches the slot phase it occupies. The two stages never hold the same tag. A result only appears for an active tag, and never twice in a row for the same tag.

The bench sweeps every normalized modulus of an 8-bit configuration, with both edge and pseudo-random operands, running two jobs interleaved. Only these scenarios can show that the final corrected value equals the product. They also show the start-to-done latency, and that a start to a busy tag leaves the running job untouched.

// File: rtl/csmm_pkg.sv
package csmm_pkg;
  typedef enum logic [1:0] {
    Q_HOLD = 2'b00,
    Q_ADD  = 2'b01,
    Q_SUB  = 2'b10
  } qsel_e;

  function automatic qsel_e qsel_decode(input logic pos, input logic neg);
    if (pos)      return Q_SUB;
    else if (neg) return Q_ADD;
    else          return Q_HOLD;
  endfunction
endpackage

// File: rtl/csmm_csa.sv
module csmm_csa #(
  parameter int W = 21
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] maj;
  assign s_o = x_i ^ y_i ^ z_i;
  assign maj = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign c_o = {maj[W-2:0], cin_i};
endmodule

// File: rtl/csmm_estimate.sv
module csmm_estimate import csmm_pkg::*; #(
  parameter int N = 16,
  parameter int W = N + 5
) (
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  output qsel_e        q_o
);
  localparam int T = N - 2;  // truncated low bits, granule = eps/2
  localparam logic signed [W-1:0] POS_TH = W'(2 ** N);
  localparam logic signed [W-1:0] NEG_TH = W'(-(2 ** (N + 1)));

  logic [W-1:0] y;
  logic         pos, neg;

  assign y   = {s_i[W-1:T], {T{1'b0}}} + {c_i[W-1:T], {T{1'b0}}};
  assign pos = $signed(y) >= POS_TH;
  assign neg = $signed(y) <= NEG_TH;
  assign q_o = qsel_decode(pos, neg);
endmodule

// File: rtl/csmm_mul.sv
module csmm_mul import csmm_pkg::*; #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         tag_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] m_i,
  output logic         done_o,
  output logic         tag_o,
  output logic [N+4:0] sum_o,
  output logic [N+4:0] carry_o
);
  localparam int W  = N + 5;
  localparam int IW = $clog2(N + 3);
  localparam logic [IW-1:0] TOP_IX = IW'(N + 2);

  logic         ph;
  logic [1:0]   busy, pend;
  logic [N-1:0] a_q [2];
  logic [N-1:0] b_q [2];
  logic [N-1:0] m_q [2];

  // stage 1 register
  logic          v1, tg1, last1;
  logic [IW-1:0] ix1;
  logic [W-1:0]  s1, c1;
  qsel_e         q1;
  // stage 2 register (accumulator between steps)
  logic          v2, tg2, last2;
  logic [IW-1:0] ix2;
  logic [W-1:0]  s2, c2;

  logic          cont, go, abit;
  logic [IW-1:0] ix_in;
  logic [W-1:0]  s_in, c_in, addend, s1_n, c1_n;
  logic [W-1:0]  mhat, rz, s2_n, c2_n;
  logic [N+2:0]  ahat;
  qsel_e         q_n;

  assign cont   = v2 && !last2 && (tg2 == ph);
  assign go     = cont || pend[ph];
  assign s_in   = cont ? s2 : '0;
  assign c_in   = cont ? c2 : '0;
  assign ix_in  = cont ? ix2 - 1'b1 : TOP_IX;
  assign ahat   = {a_q[ph], 3'b000};
  assign abit   = ahat[ix_in];
  assign addend = abit ? {{(W-N){1'b0}}, b_q[ph]} : '0;

  csmm_estimate #(.N(N), .W(W)) u_est (
    .s_i (s_in),
    .c_i (c_in),
    .q_o (q_n)
  );

  csmm_csa #(.W(W)) u_shift_add (
    .x_i   ({s_in[W-2:0], 1'b0}),
    .y_i   ({c_in[W-2:0], 1'b0}),
    .z_i   (addend),
    .cin_i (1'b0),
    .s_o   (s1_n),
    .c_o   (c1_n)
  );

  assign mhat = {2'b00, m_q[tg1], 3'b000};
  always_comb begin
    case (q1)
      Q_SUB:   rz = ~mhat;
      Q_ADD:   rz = mhat;
      default: rz = '0;
    endcase
  end

  csmm_csa #(.W(W)) u_reduce (
    .x_i   (s1),
    .y_i   (c1),
    .z_i   (rz),
    .cin_i (q1 == Q_SUB),
    .s_o   (s2_n),
    .c_o   (c2_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph <= 1'b0; busy <= '0; pend <= '0;
      for (int t = 0; t < 2; t++) begin
        a_q[t] <= '0; b_q[t] <= '0; m_q[t] <= '0;
      end
      v1 <= 1'b0; tg1 <= 1'b0; last1 <= 1'b0; ix1 <= '0;
      s1 <= '0; c1 <= '0; q1 <= Q_HOLD;
      v2 <= 1'b0; tg2 <= 1'b0; last2 <= 1'b0; ix2 <= '0;
      s2 <= '0; c2 <= '0;
    end else begin
      ph <= ~ph;
      if (go && !cont) pend[ph] <= 1'b0;
      if (v2 && last2) busy[tg2] <= 1'b0;
      for (int t = 0; t < 2; t++) begin
        if (start_i && tag_i == 1'(t) && !busy[t]) begin
          busy[t] <= 1'b1; pend[t] <= 1'b1;
          a_q[t] <= a_i; b_q[t] <= b_i; m_q[t] <= m_i;
        end
      end
      v1 <= go;
      if (go) begin
        s1 <= s1_n; c1 <= c1_n; q1 <= q_n;
        tg1 <= ph; ix1 <= ix_in; last1 <= (ix_in == '0);
      end
      v2 <= v1;
      if (v1) begin
        s2 <= s2_n; c2 <= c2_n;
        tg2 <= tg1; ix2 <= ix1; last2 <= last1;
      end
    end
  end

  assign done_o  = v2 && last2;
  assign tag_o   = tg2;
  assign sum_o   = s2;
  assign carry_o = c2;
endmodule

// File: rtl/csmm_mul_chk.sv
module csmm_mul_chk #(
  parameter int N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         tag_i,
  input logic [N-1:0] m_i,
  input logic         done_o,
  input logic         tag_o,
  input logic         ph,
  input logic [1:0]   busy,
  input logic         v1,
  input logic         tg1,
  input logic         v2,
  input logic         tg2,
  input logic [N+4:0] s2,
  input logic [N+4:0] c2
);
  logic [N-1:0] m_ref [2];
  logic [N+4:0] xs;
  int           xv, mv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ref[0] <= '0; m_ref[1] <= '0;
    end else if (start_i && !busy[tag_i]) begin
      m_ref[tag_i] <= m_i;
    end
  end

  assign xs = s2 + c2;
  assign xv = int'($signed(xs));
  assign mv = int'(m_ref[tg2]);

  p_acc_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 |-> (xv >= -8 * mv && xv <= 7 * mv));

  p_tag_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 |-> tg2 == ph);

  p_stage_split_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1 && v2) |-> tg1 != tg2);

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !(done_o && tag_o == $past(tag_o)));

  p_done_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy[tag_o]);
endmodule

bind csmm_mul csmm_mul_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .tag_i   (tag_i),
  .m_i     (m_i),
  .done_o  (done_o),
  .tag_o   (tag_o),
  .ph      (ph),
  .busy    (busy),
  .v1      (v1),
  .tg1     (tg1),
  .v2      (v2),
  .tg2     (tg2),
  .s2      (s2),
  .c2      (c2)
);

// File: tb/csmm_mul_tb.sv
module csmm_mul_tb;
  localparam int N = 8;
  localparam int W = N + 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         tag_i = 1'b0;
  logic [N-1:0] a_i = '0, b_i = '0, m_i = '0;
  logic         done_o, tag_o;
  logic [W-1:0] sum_o, carry_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int unsigned seed = 32'h1234_5678;

  csmm_mul #(.N(N)) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .tag_i (tag_i),
    .a_i (a_i), .b_i (b_i), .m_i (m_i),
    .done_o (done_o), .tag_o (tag_o), .sum_o (sum_o), .carry_o (carry_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int lim);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % lim);
  endfunction

  // R1 R2 R7 R8: decode carry-save result and compare with A*B mod M
  task automatic check_res(input int a, input int b, input int m, input string req);
    logic [W-1:0] xs;
    int xv, r, e;
    xs = sum_o + carry_o;
    xv = int'($signed(xs));
    check(xv >= -8 * m && xv <= 7 * m, "R2 range", xv, 7 * m);
    r = (xv < 0) ? xv + 8 * m : xv;
    check(r % 8 == 0, "R1 low bits", r % 8, 0);
    e = (a * b) % m;
    check(r / 8 == e, req, r / 8, e);
  endtask

  task automatic run_pair(input int a0, input int b0, input int a1, input int b1,
                          input int m, input string req);
    int st0, st1;
    bit got0, got1;
    @(negedge clk);
    start_i = 1'b1; tag_i = 1'b0; a_i = N'(a0); b_i = N'(b0); m_i = N'(m); st0 = cyc + 1;
    @(negedge clk);
    tag_i = 1'b1; a_i = N'(a1); b_i = N'(b1); st1 = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
    got0 = 1'b0; got1 = 1'b0;
    for (int w = 0; w < 60 && !(got0 && got1); w++) begin
      if (done_o) begin
        if (tag_o == 1'b0) begin
          check(!got0, "R3 single result tag0", 1, 0);
          got0 = 1'b1;
          check_res(a0, b0, m, req);
          check(cyc - st0 == 2 * N + 6 || cyc - st0 == 2 * N + 7, "R4 latency", cyc - st0, 2 * N + 6);
        end else begin
          check(!got1, "R3 single result tag1", 1, 0);
          got1 = 1'b1;
          check_res(a1, b1, m, req);
          check(cyc - st1 == 2 * N + 6 || cyc - st1 == 2 * N + 7, "R4 latency", cyc - st1, 2 * N + 6);
        end
      end
      @(negedge clk);
    end
    check(got0 && got1, "R3 both tags returned", int'(got0) + int'(got1), 2);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R6: idle after reset
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(!done_o && sum_o == '0 && carry_o == '0, "R6 idle", int'(done_o), 0);
    end

    // R5: a second start to a busy tag is ignored
    begin
      int got;
      @(negedge clk);
      start_i = 1'b1; tag_i = 1'b0; a_i = 8'd200; b_i = 8'd150; m_i = 8'd251;
      @(negedge clk);
      a_i = 8'd17; b_i = 8'd3; m_i = 8'd130;
      @(negedge clk);
      start_i = 1'b0;
      got = 0;
      for (int w = 0; w < 100; w++) begin
        if (done_o) begin
          got++;
          if (got == 1) check_res(200, 150, 251, "R5 original result");
        end
        @(negedge clk);
      end
      check(got == 1, "R5 one result", got, 1);
    end

    // R8 edges, R1/R7 sweep over every normalized modulus
    for (int m = 128; m < 256; m++) begin
      run_pair(0, m - 1, m - 1, m - 1, m, "R8 edge");
      for (int p = 0; p < 8; p++)
        run_pair(rnd(m), rnd(m), rnd(m), rnd(m), m, (m % 2 == 0) ? "R7 even" : "R1 odd");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule